// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous EDO DRAM alive. After reset it waits out the power-up pause that the memory needs. It then runs a burst of CAS-before-RAS refresh cycles to initialise the memory. Only then does it raise `init_done`, which tells the rest of the memory subsystem that normal accesses may begin.

From that point on, an interval timer adds one owed refresh to a small backlog at a fixed cadence. For a memory of 8192 rows refreshed every 128 ms, this cadence is about 15.6 µs. The backlog lets the access controller postpone refreshes while it is busy. A non-empty backlog raises `refresh_req`, and a full backlog also raises `refresh_urgent`.

The access controller answers with `bus_grant`. While the block drives the RAS and CAS strobes it holds `bus_own` high. Refresh uses the memory's internal row counter, so the block drives no address. It also keeps write enable high, so that a refresh cycle can never be taken as a test-mode entry.

Top module: `rfsh_sequencer`

## Requirements
- R1: After reset release, for the first PAUSE_CYC clock edges `refresh_req` stays 0, `init_done` stays 0 and both strobes stay high, whatever `bus_grant` does.
- R2: At the edge that ends the pause, `refresh_req` rises. INIT_CNT refresh cycles then run while it is granted. `init_done` rises at the edge that ends the last precharge, and never falls again until reset.
- R3: Each refresh cycle has three parts. CAS falls first and stays low with RAS high for CSR_CYC cycles. RAS is then low for max(RAS_CYC, CHR_CYC) cycles with CAS low throughout. Both strobes then rise on the same edge.
- R4: After each refresh cycle both strobes stay high for at least RP_CYC cycles before CAS can fall again.
- R5: `dram_we_n` is 1 at all times, including at every RAS falling edge.
- R6: Once `init_done` is set, one refresh is added to the backlog every REFI_CYC cycles. The first is added REFI_CYC edges after the edge that raised `init_done`.
- R7: After initialisation, `refresh_req` is 1 exactly when the backlog is non-zero. `refresh_urgent` is 1 exactly when the backlog equals PEND_MAX.
- R8: The backlog saturates at PEND_MAX. Intervals that elapse while it is full are lost, so a later drain performs exactly PEND_MAX cycles.
- R9: A refresh cycle starts at the edge after a cycle in which both `bus_grant` and the request are high. `bus_own` covers every cycle in which a strobe is low. A grant while no refresh is owed starts nothing.
- R10: A held grant drains the backlog back to back, one cycle every CSR_CYC+max(RAS_CYC,CHR_CYC)+RP_CYC+1 clocks. The backlog drops by one at each start, and `refresh_req` falls at the start of the last owed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Access controller hands the memory bus to this block |
| refresh_req | output | 1 | Refresh owed (initial burst or non-empty backlog) |
| refresh_urgent | output | 1 | Backlog is full |
| bus_own | output | 1 | Block is driving the memory strobes |
| init_done | output | 1 | Power-up pause and initial refresh burst finished |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low, held high |

## Verification
Some properties are checked on every cycle. These are the strobe shape: CAS setup before RAS falls, CAS held while RAS is low, minimum RAS low time and minimum precharge. Also checked on every cycle are that no strobe or request appears before the pause has elapsed, that the bus is owned whenever a strobe is active, that ownership follows a grant, that `init_done` is sticky, and that urgency implies a request.

Other behaviours depend on counting over long windows, and only the bench scenarios show them. These are the exact edges at which the pause ends and the backlog grows, that a full backlog stops counting, and that a drain performs exactly the saturated number of cycles back to back. The bench also shows that a grant with nothing owed is ignored.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE = 3'd0,
        ST_WAIT  = 3'd1,
        ST_SETUP = 3'd2,
        ST_HOLD  = 3'd3,
        ST_PRECH = 3'd4
    } rfsh_state_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic at_end;

    always_comb begin
        d      = q;
        at_end = (q.cnt == W'(PERIOD - 1));
        tick   = en && at_end;
        if (en) begin
            if (at_end) d.cnt = '0;
            else        d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pending_nz,
    output logic full
);
    localparam int unsigned W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } blog_t;

    blog_t d, q;

    always_comb begin
        d          = q;
        pending_nz = (q.cnt != '0);
        full       = (q.cnt == W'(DEPTH));
        unique case ({tick, take})
            2'b10: if (!full)      d.cnt = q.cnt + 1'b1;
            2'b01: if (pending_nz) d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/rfsh_cbr_fsm.sv
module rfsh_cbr_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 10_000_000,
    parameter int unsigned INIT_CNT  = 8,
    parameter int unsigned CSR_CYC   = 1,
    parameter int unsigned LOW_CYC   = 4,
    parameter int unsigned RP_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic backlog_nz,
    output logic take,
    output logic ready,
    output logic init_req,
    output logic ras_n,
    output logic cas_n,
    output logic own
);
    localparam int unsigned CMAX = imax(imax(PAUSE_CYC, CSR_CYC), imax(LOW_CYC, RP_CYC));
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam int unsigned IW   = $clog2(INIT_CNT + 1);

    typedef struct packed {
        rfsh_state_e   state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] init_left;
        logic          ready;
    } fsm_t;

    fsm_t d, q;
    logic go;

    always_comb begin
        d    = q;
        take = 1'b0;
        go   = grant && (!q.ready || backlog_nz);
        unique case (q.state)
            ST_PAUSE: begin
                if (q.cnt == CW'(PAUSE_CYC - 1)) begin
                    d.state = ST_WAIT;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (go) begin
                    d.state = ST_SETUP;
                    d.cnt   = '0;
                    if (q.ready) take = 1'b1;
                    else         d.init_left = q.init_left - 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.cnt == CW'(CSR_CYC - 1)) begin
                    d.state = ST_HOLD;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (q.cnt == CW'(LOW_CYC - 1)) begin
                    d.state = ST_PRECH;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_PRECH: begin
                if (q.cnt == CW'(RP_CYC - 1)) begin
                    d.state = ST_WAIT;
                    d.cnt   = '0;
                    if (!q.ready && q.init_left == '0) d.ready = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.state = ST_PAUSE;
                d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_PAUSE;
            q.cnt       <= '0;
            q.init_left <= IW'(INIT_CNT);
            q.ready     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ready    = q.ready;
    assign init_req = !q.ready && (q.state != ST_PAUSE);
    assign ras_n    = (q.state != ST_HOLD);
    assign cas_n    = !((q.state == ST_SETUP) || (q.state == ST_HOLD));
    assign own      = (q.state == ST_SETUP) || (q.state == ST_HOLD) || (q.state == ST_PRECH);
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
    import rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 10_000_000,
    parameter int unsigned INIT_CNT  = 8,
    parameter int unsigned REFI_CYC  = 1560,
    parameter int unsigned PEND_MAX  = 8,
    parameter int unsigned CSR_CYC   = 1,
    parameter int unsigned RAS_CYC   = 4,
    parameter int unsigned CHR_CYC   = 1,
    parameter int unsigned RP_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_grant,
    output logic refresh_req,
    output logic refresh_urgent,
    output logic bus_own,
    output logic init_done,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n
);
    // RAS low time must cover both the minimum pulse and the CAS hold after RAS falls
    localparam int unsigned LOW_CYC = imax(RAS_CYC, CHR_CYC);

    logic tick, take, pend_nz, pend_full, init_req, ready;

    rfsh_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ready),
        .tick (tick)
    );

    rfsh_backlog #(.DEPTH(PEND_MAX)) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .take      (take),
        .pending_nz(pend_nz),
        .full      (pend_full)
    );

    rfsh_cbr_fsm #(
        .PAUSE_CYC(PAUSE_CYC),
        .INIT_CNT (INIT_CNT),
        .CSR_CYC  (CSR_CYC),
        .LOW_CYC  (LOW_CYC),
        .RP_CYC   (RP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (bus_grant),
        .backlog_nz(pend_nz),
        .take      (take),
        .ready     (ready),
        .init_req  (init_req),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .own       (bus_own)
    );

    assign init_done      = ready;
    assign refresh_req    = init_req || (ready && pend_nz);
    assign refresh_urgent = pend_full;
    assign dram_we_n      = 1'b1;
endmodule

// File: rtl/rfsh_sequencer_chk.sv
module rfsh_sequencer_chk #(
    parameter int unsigned PAUSE_CYC = 10_000_000,
    parameter int unsigned CSR_CYC   = 1,
    parameter int unsigned RAS_CYC   = 4,
    parameter int unsigned CHR_CYC   = 1,
    parameter int unsigned RP_CYC    = 3
) (
    input logic clk,
    input logic rst_n,
    input logic bus_grant,
    input logic refresh_req,
    input logic refresh_urgent,
    input logic bus_own,
    input logic init_done,
    input logic dram_ras_n,
    input logic dram_cas_n
);
    localparam int unsigned LOW_CYC = (RAS_CYC > CHR_CYC) ? RAS_CYC : CHR_CYC;

    logic [31:0] since_q;
    logic [15:0] su_q, lo_q, pr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            su_q    <= '0;
            lo_q    <= '0;
            pr_q    <= 16'hFFFF;
        end else begin
            if (since_q < 32'(PAUSE_CYC)) since_q <= since_q + 1'b1;
            su_q <= (!dram_cas_n && dram_ras_n) ? ((su_q == 16'hFFFF) ? su_q : su_q + 1'b1) : '0;
            lo_q <= (!dram_ras_n) ? ((lo_q == 16'hFFFF) ? lo_q : lo_q + 1'b1) : '0;
            pr_q <= (dram_ras_n && dram_cas_n) ? ((pr_q == 16'hFFFF) ? pr_q : pr_q + 1'b1) : '0;
        end
    end

    assert_no_strobe_in_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> (since_q >= 32'(PAUSE_CYC)));
    assert_no_req_in_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> (since_q >= 32'(PAUSE_CYC)));
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    assert_cas_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (su_q >= 16'(CSR_CYC)));
    assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> !dram_cas_n);
    assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (lo_q >= 16'(LOW_CYC)));
    assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (pr_q >= 16'(RP_CYC)));
    assert_urgent_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_urgent |-> refresh_req);
    assert_strobes_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n || !dram_cas_n) |-> bus_own);
    assert_own_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(bus_grant));
endmodule

bind rfsh_sequencer rfsh_sequencer_chk #(
    .PAUSE_CYC(PAUSE_CYC),
    .CSR_CYC  (CSR_CYC),
    .RAS_CYC  (RAS_CYC),
    .CHR_CYC  (CHR_CYC),
    .RP_CYC   (RP_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_grant     (bus_grant),
    .refresh_req   (refresh_req),
    .refresh_urgent(refresh_urgent),
    .bus_own       (bus_own),
    .init_done     (init_done),
    .dram_ras_n    (dram_ras_n),
    .dram_cas_n    (dram_cas_n)
);

// File: tb/rfsh_sequencer_bench.sv
module rfsh_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_PAUSE = 50;
    localparam int P_INIT  = 8;
    localparam int P_REFI  = 100;
    localparam int P_PEND  = 8;
    localparam int P_CSR   = 2;
    localparam int P_RAS   = 4;
    localparam int P_CHR   = 2;
    localparam int P_RP    = 3;
    localparam int EXP_LOW = (P_RAS > P_CHR) ? P_RAS : P_CHR;
    localparam int PERIOD_CBR = P_CSR + EXP_LOW + P_RP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_grant = 1'b0;
    logic refresh_req, refresh_urgent, bus_own, init_done;
    logic dram_ras_n, dram_cas_n, dram_we_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pops   = 0;
    int e0     = 0;
    bit done   = 1'b0;

    typedef struct {
        int su;
        int lo;
    } cbr_item_t;
    cbr_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_sequencer #(
        .PAUSE_CYC(P_PAUSE), .INIT_CNT(P_INIT), .REFI_CYC(P_REFI), .PEND_MAX(P_PEND),
        .CSR_CYC(P_CSR), .RAS_CYC(P_RAS), .CHR_CYC(P_CHR), .RP_CYC(P_RP)
    ) u_rfsh_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
        .refresh_req(refresh_req), .refresh_urgent(refresh_urgent),
        .bus_own(bus_own), .init_done(init_done),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push_cbr(input int n);
        for (int i = 0; i < n; i++) begin
            cbr_item_t it;
            it.su = P_CSR;
            it.lo = EXP_LOW;
            exp_q.push_back(it);
        end
    endtask

    task automatic at_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Monitor: measures each refresh pulse and compares against the scoreboard
    int su_cnt = 0, lo_cnt = 0, we_bad = 0;
    logic prev_ras = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_we_n !== 1'b1) we_bad++;
            if (!dram_cas_n && dram_ras_n) su_cnt++;
            if (!dram_ras_n) lo_cnt++;
            if (!prev_ras && dram_ras_n) begin
                pops++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected refresh cycle", pops, 0);
                end else begin
                    cbr_item_t it;
                    it = exp_q.pop_front();
                    chk(su_cnt == it.su, "R3 CAS setup cycles", su_cnt, it.su);
                    chk(lo_cnt == it.lo, "R3 RAS low cycles", lo_cnt, it.lo);
                    chk(dram_cas_n == 1'b1, "R3 CAS rises with RAS", int'(dram_cas_n), 1);
                end
                su_cnt = 0;
                lo_cnt = 0;
            end
            prev_ras = dram_ras_n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n, "R1 reset strobes high", int'({dram_ras_n, dram_cas_n}), 3);
        chk(!refresh_req && !init_done, "R1 reset req/done low", int'({refresh_req, init_done}), 0);
        chk(dram_we_n == 1'b1, "R5 reset WE high", int'(dram_we_n), 1);
        bus_grant = 1'b1;   // grant during the pause must be ignored
        push_cbr(P_INIT);
        rst_n = 1'b1;

        // R1: pause window
        at_cyc(P_PAUSE - 1);
        chk(!refresh_req, "R1 req low at end of pause", int'(refresh_req), 0);
        chk(dram_cas_n && !bus_own, "R1 no strobe in pause", int'(dram_cas_n), 1);
        // R2: request at the edge ending the pause, then the init burst
        at_cyc(P_PAUSE);
        chk(refresh_req && !init_done, "R2 init request", int'(refresh_req), 1);
        at_cyc(P_PAUSE + 1);
        chk(bus_own && !dram_cas_n, "R9 cycle starts after grant", int'(bus_own), 1);
        e0 = P_PAUSE + P_INIT * PERIOD_CBR;
        at_cyc(e0 - 1);
        chk(!init_done, "R2 done low before last precharge ends", int'(init_done), 0);
        at_cyc(e0);
        chk(init_done, "R2 done after init burst", int'(init_done), 1);
        chk(pops == P_INIT, "R2 init cycle count", pops, P_INIT);
        bus_grant = 1'b0;

        // R6: first interval
        at_cyc(e0 + P_REFI - 1);
        chk(!refresh_req, "R6 req low before first interval", int'(refresh_req), 0);
        at_cyc(e0 + P_REFI);
        chk(refresh_req && !refresh_urgent, "R6/R7 req after first interval", int'(refresh_req), 1);
        // R7: urgency when backlog fills
        at_cyc(e0 + P_PEND * P_REFI - 1);
        chk(!refresh_urgent, "R7 not urgent one short of full", int'(refresh_urgent), 0);
        at_cyc(e0 + P_PEND * P_REFI);
        chk(refresh_urgent && refresh_req, "R7 urgent when full", int'(refresh_urgent), 1);
        chk(dram_ras_n && !bus_own, "R9 no cycle without grant", int'(bus_own), 0);

        // R8/R10: saturated backlog drained with a held grant
        at_cyc(e0 + 1104);
        chk(refresh_urgent, "R8 still full after extra intervals", int'(refresh_urgent), 1);
        push_cbr(P_PEND);
        bus_grant = 1'b1;
        at_cyc(e0 + 1105);
        chk(!refresh_urgent && bus_own, "R10 backlog drops at start", int'(refresh_urgent), 0);
        at_cyc(e0 + 1105 + (P_PEND - 1) * PERIOD_CBR - 1);
        chk(refresh_req, "R10 req held before last start", int'(refresh_req), 1);
        at_cyc(e0 + 1105 + (P_PEND - 1) * PERIOD_CBR);
        chk(!refresh_req, "R10 req falls at last start", int'(refresh_req), 0);
        at_cyc(e0 + 1190);
        chk(pops == P_INIT + P_PEND, "R8 drain performs exactly PEND_MAX cycles", pops - P_INIT, P_PEND);

        // R6: cadence continues; grant still held
        push_cbr(1);
        at_cyc(e0 + 12 * P_REFI - 1);
        chk(!refresh_req, "R6 req low before next interval", int'(refresh_req), 0);
        at_cyc(e0 + 12 * P_REFI);
        chk(refresh_req, "R6 next interval adds refresh", int'(refresh_req), 1);
        at_cyc(e0 + 12 * P_REFI + 1);
        chk(bus_own && !refresh_req, "R9 immediate service under grant", int'(bus_own), 1);

        // R9: grant held with nothing owed starts nothing
        at_cyc(e0 + 1295);
        chk(pops == P_INIT + P_PEND + 1, "R9 grant ignored with empty backlog", pops, P_INIT + P_PEND + 1);
        chk(dram_ras_n && dram_cas_n && !bus_own, "R9 idle strobes", int'(bus_own), 0);
        bus_grant = 1'b0;
        repeat (5) @(negedge clk);

        chk(exp_q.size() == 0, "R3 all expected cycles seen", exp_q.size(), 0);
        chk(we_bad == 0, "R5 WE never low", we_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule